// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

Two processors share one memory through a left and a right port. This block reserves the two highest words of the address space as mailboxes and turns accesses to them into interrupts. When the left port writes the highest word, the right port's interrupt goes active. It stays active until the right port reads that same word. The word just below works the other way round: a right-port write raises the left interrupt, and a left-port read clears it. The memory array is not part of this block. The block only watches each port's address, chip enable, read/write and output enable lines.

An arbiter outside the block reports, for each port, whether that port is being held off. An access can change a flag only if one of two things is true: the two ports are not both enabled on the same address, or the acting port is not the one held off. Each flag is a registered set/reset bit that updates on the clock edge that samples the access. A port in standby, with its chip enable inactive, leaves both flags untouched. Both interrupt outputs are active low.

Top module: `mbox_irq`

## Requirements
- R1: After reset both interrupt outputs are high (inactive).
- R2: A left write (`l_cs_n`=0, `l_rw`=0) to the highest address (all ones) drives `r_irq_n` low from the clock edge that samples it. `l_oe_n` has no effect on this.
- R3: A right read of the highest address clears `r_irq_n` to high on the sampling edge. A read here means `r_cs_n`=0, `r_rw`=1 and `r_oe_n`=0.
- R4: A right write to the second-highest address (all ones except bit 0) drives `l_irq_n` low on the sampling edge.
- R5: A left read of the second-highest address, with `l_cs_n`=0, `l_rw`=1 and `l_oe_n`=0, clears `l_irq_n` to high on the sampling edge.
- R6: Only the opposite port's read clears a flag. The raising port reading its own mailbox leaves the flag low. A write to a mailbox by the port that is meant to read it leaves the flag unchanged.
- R7: While a port's chip enable is high, that port's accesses have no effect. A standby of any length keeps both flags as they are.
- R8: A read with the output enable high does not clear a flag.
- R9: An access has no effect if both chip enables are low, the addresses are equal, and the acting port's busy input is high. When the addresses differ, a high busy input does not block the access.
- R10: When a set and a clear of the same flag fall in one cycle, the flag ends up set.
- R11: Accesses to any address other than the two mailbox words leave both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_addr | input | AW | Left port word address |
| l_cs_n | input | 1 | Left chip enable, active low |
| l_rw | input | 1 | Left direction, 1 read, 0 write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_busy | input | 1 | Arbiter holds the left port off |
| r_addr | input | AW | Right port word address |
| r_cs_n | input | 1 | Right chip enable, active low |
| r_rw | input | 1 | Right direction, 1 read, 0 write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_busy | input | 1 | Arbiter holds the right port off |
| l_irq_n | output | 1 | Interrupt to the left port, active low |
| r_irq_n | output | 1 | Interrupt to the right port, active low |

## Verification
Each flag is a single state bit, and that bit drives its output pin directly. A wrong state therefore shows on `l_irq_n` or `r_irq_n` one edge after the access that caused it. A missed set, a clear by the wrong port, or a clear that should have been blocked all show up as a flipped output level at the next sample. The bench also makes a stuck flag visible: after each no-effect stimulus it checks the level, then follows with a genuine set or clear.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef struct packed {
        logic raise;  // set the flag of the opposite port
        logic drop;   // clear this port's own flag
    } mb_evt_t;

    typedef struct packed {
        logic pend;   // interrupt pending
    } mb_flag_t;

endpackage

// File: rtl/mbox_port_dec.sv
module mbox_port_dec
    import mbox_pkg::*;
#(
    parameter int              AW         = 10,
    parameter logic [AW-1:0]   RAISE_ADDR = '1,
    parameter logic [AW-1:0]   DROP_ADDR  = '1
) (
    input  logic [AW-1:0] addr,
    input  logic          cs_n,
    input  logic          rw,
    input  logic          oe_n,
    input  logic          busy,
    input  logic          clash,
    output mb_evt_t       evt
);

    logic granted;

    always_comb begin
        granted   = !cs_n && !(clash && busy);
        evt.raise = granted && !rw && (addr == RAISE_ADDR);
        evt.drop  = granted && rw && !oe_n && (addr == DROP_ADDR);
    end

endmodule

// File: rtl/mbox_flag.sv
module mbox_flag
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic irq_n
);

    mb_flag_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) st_d.pend = 1'b0;
        if (set) st_d.pend = 1'b1;   // set has the last word
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_n = !st_q.pend;

endmodule

// File: rtl/mbox_irq.sv
module mbox_irq
    import mbox_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] l_addr,
    input  logic          l_cs_n,
    input  logic          l_rw,
    input  logic          l_oe_n,
    input  logic          l_busy,
    input  logic [AW-1:0] r_addr,
    input  logic          r_cs_n,
    input  logic          r_rw,
    input  logic          r_oe_n,
    input  logic          r_busy,
    output logic          l_irq_n,
    output logic          r_irq_n
);

    localparam int            NPORT    = 2;
    localparam logic [AW-1:0] BOX_TO_R = '1;
    localparam logic [AW-1:0] BOX_TO_L = BOX_TO_R - AW'(1);

    logic [NPORT-1:0][AW-1:0] p_addr;
    logic [NPORT-1:0]         p_cs_n, p_rw, p_oe_n, p_busy;
    mb_evt_t [NPORT-1:0]      p_evt;
    logic                     clash;

    always_comb begin
        p_addr = {r_addr, l_addr};
        p_cs_n = {r_cs_n, l_cs_n};
        p_rw   = {r_rw,   l_rw};
        p_oe_n = {r_oe_n, l_oe_n};
        p_busy = {r_busy, l_busy};
        clash  = !l_cs_n && !r_cs_n && (l_addr == r_addr);
    end

    // port 0 = left, port 1 = right
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam logic [AW-1:0] RAISE = (p == 0) ? BOX_TO_R : BOX_TO_L;
        localparam logic [AW-1:0] DROP  = (p == 0) ? BOX_TO_L : BOX_TO_R;

        mbox_port_dec #(
            .AW         (AW),
            .RAISE_ADDR (RAISE),
            .DROP_ADDR  (DROP)
        ) i_dec (
            .addr  (p_addr[p]),
            .cs_n  (p_cs_n[p]),
            .rw    (p_rw[p]),
            .oe_n  (p_oe_n[p]),
            .busy  (p_busy[p]),
            .clash (clash),
            .evt   (p_evt[p])
        );
    end

    mbox_flag i_flag_l (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (p_evt[1].raise),
        .clr   (p_evt[0].drop),
        .irq_n (l_irq_n)
    );

    mbox_flag i_flag_r (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (p_evt[0].raise),
        .clr   (p_evt[1].drop),
        .irq_n (r_irq_n)
    );

endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] l_addr,
    input logic          l_cs_n,
    input logic          l_rw,
    input logic          l_oe_n,
    input logic          l_busy,
    input logic [AW-1:0] r_addr,
    input logic          r_cs_n,
    input logic          r_rw,
    input logic          r_oe_n,
    input logic          r_busy,
    input logic          l_irq_n,
    input logic          r_irq_n
);

    localparam logic [AW-1:0] HI = '1;
    localparam logic [AW-1:0] LO = HI - AW'(1);

    logic same, l_ok, r_ok, set_r, clr_r, set_l, clr_l;

    always_comb begin
        same  = (l_addr == r_addr) && !l_cs_n && !r_cs_n;
        l_ok  = !l_cs_n && (!same || !l_busy);
        r_ok  = !r_cs_n && (!same || !r_busy);
        set_r = l_ok && !l_rw && (l_addr == HI);
        clr_r = r_ok && r_rw && !r_oe_n && (r_addr == HI);
        set_l = r_ok && !r_rw && (r_addr == LO);
        clr_l = l_ok && l_rw && !l_oe_n && (l_addr == LO);
    end

    AST_R_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_r |=> !r_irq_n);                                  // R2
    AST_R_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_r && !set_r) |=> r_irq_n);                       // R3
    AST_L_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_l |=> !l_irq_n);                                  // R4
    AST_L_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_l && !set_l) |=> l_irq_n);                       // R5
    AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_r && !clr_r) |=> $stable(r_irq_n));             // R9
    AST_L_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_l && !clr_l) |=> $stable(l_irq_n));             // R9

endmodule

bind mbox_irq mbox_irq_chk #(.AW(AW)) i_mbox_irq_chk (.*);

// File: tb/test_mbox_irq.sv
`timescale 1ns/1ps
module test_mbox_irq;

    localparam int AW = 10;
    localparam logic [AW-1:0] HI = 10'h3FF;
    localparam logic [AW-1:0] LO = 10'h3FE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic          l_cs_n = 1'b1, l_rw = 1'b1, l_oe_n = 1'b1, l_busy = 1'b0;
    logic          r_cs_n = 1'b1, r_rw = 1'b1, r_oe_n = 1'b1, r_busy = 1'b0;
    logic          l_irq_n, r_irq_n;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    mbox_irq #(.AW(AW)) i_mbox_irq (.*);

    task automatic chk(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %b exp %b", tag, got, exp);
        end
    endtask

    task automatic idle();
        l_cs_n = 1; l_rw = 1; l_oe_n = 1; l_busy = 0; l_addr = '0;
        r_cs_n = 1; r_rw = 1; r_oe_n = 1; r_busy = 0; r_addr = '0;
    endtask

    // cs_n, rw, oe_n, busy, addr
    task automatic lp(input logic cs, input logic rw, input logic oe,
                      input logic bsy, input logic [AW-1:0] a);
        l_cs_n = cs; l_rw = rw; l_oe_n = oe; l_busy = bsy; l_addr = a;
    endtask

    task automatic rp(input logic cs, input logic rw, input logic oe,
                      input logic bsy, input logic [AW-1:0] a);
        r_cs_n = cs; r_rw = rw; r_oe_n = oe; r_busy = bsy; r_addr = a;
    endtask

    // one sampling edge, then outputs are settled; inputs return to idle
    task automatic tick();
        @(posedge clk); #1;
        idle();
    endtask

    task automatic t_reset();
        chk(l_irq_n, 1'b1, "R1 l_irq_n after reset");
        chk(r_irq_n, 1'b1, "R1 r_irq_n after reset");
    endtask

    task automatic t_left_to_right();
        lp(0, 0, 0, 0, HI); tick();
        chk(r_irq_n, 1'b0, "R2 left write top sets right irq");
        chk(l_irq_n, 1'b1, "R2 left irq untouched");
        rp(0, 1, 1, 0, HI); tick();
        chk(r_irq_n, 1'b0, "R8 read with oe high keeps flag");
        lp(0, 1, 0, 0, HI); tick();
        chk(r_irq_n, 1'b0, "R6 left read of own mailbox keeps flag");
        rp(1, 1, 0, 0, HI); tick();
        chk(r_irq_n, 1'b0, "R7 deselected right read ignored");
        rp(0, 1, 0, 0, HI); tick();
        chk(r_irq_n, 1'b1, "R3 right read top clears right irq");
    endtask

    task automatic t_right_to_left();
        rp(0, 0, 1, 0, LO); tick();
        chk(l_irq_n, 1'b0, "R4 right write top-1 sets left irq");
        chk(r_irq_n, 1'b1, "R4 right irq untouched");
        rp(0, 1, 0, 0, LO); tick();
        chk(l_irq_n, 1'b0, "R6 right read of own mailbox keeps flag");
        lp(0, 0, 1, 0, LO); tick();
        chk(l_irq_n, 1'b0, "R6 left write to its mailbox keeps flag");
        lp(0, 1, 0, 0, LO); tick();
        chk(l_irq_n, 1'b1, "R5 left read top-1 clears left irq");
    endtask

    task automatic t_standby();
        lp(0, 0, 1, 0, HI); rp(0, 0, 1, 0, LO); tick();
        for (int i = 0; i < 20; i++) tick();
        chk(l_irq_n, 1'b0, "R7 left flag kept across standby");
        chk(r_irq_n, 1'b0, "R7 right flag kept across standby");
        lp(0, 1, 0, 0, LO); rp(0, 1, 0, 0, HI); tick();
        chk(l_irq_n, 1'b1, "R5 clear after standby");
        chk(r_irq_n, 1'b1, "R3 clear after standby");
    endtask

    task automatic t_other_addr();
        lp(0, 0, 1, 0, 10'h3FD); rp(0, 0, 1, 0, 10'h000); tick();
        chk(l_irq_n, 1'b1, "R11 non-mailbox write left flag");
        chk(r_irq_n, 1'b1, "R11 non-mailbox write right flag");
        lp(0, 0, 0, 0, HI); tick();
        chk(r_irq_n, 1'b0, "R2 write with oe low still sets");
        lp(0, 1, 0, 0, 10'h1FF); rp(0, 1, 0, 0, 10'h3FD); tick();
        chk(r_irq_n, 1'b0, "R11 non-mailbox reads keep flag");
        rp(0, 1, 0, 0, HI); tick();
        chk(r_irq_n, 1'b1, "R3 clear");
    endtask

    task automatic t_blocked();
        rp(0, 0, 1, 1, LO); lp(0, 1, 1, 0, LO); tick();
        chk(l_irq_n, 1'b1, "R9 blocked right write does not set");
        rp(0, 0, 1, 1, LO); lp(0, 1, 1, 0, 10'h010); tick();
        chk(l_irq_n, 1'b0, "R9 busy with different address still sets");
        lp(0, 1, 0, 1, LO); rp(0, 1, 1, 0, LO); tick();
        chk(l_irq_n, 1'b0, "R9 blocked left read does not clear");
        lp(0, 1, 0, 1, LO); rp(1, 1, 1, 0, LO); tick();
        chk(l_irq_n, 1'b1, "R9 busy with other port deselected clears");
        lp(0, 0, 1, 1, HI); rp(0, 1, 1, 0, HI); tick();
        chk(r_irq_n, 1'b1, "R9 blocked left write does not set");
    endtask

    task automatic t_set_wins();
        lp(0, 0, 1, 0, HI); rp(0, 1, 0, 0, HI); tick();
        chk(r_irq_n, 1'b0, "R10 set beats clear from idle");
        lp(0, 0, 1, 0, HI); rp(0, 1, 0, 0, HI); tick();
        chk(r_irq_n, 1'b0, "R10 set beats clear while pending");
        rp(0, 0, 1, 0, LO); lp(0, 1, 0, 0, LO); tick();
        chk(l_irq_n, 1'b0, "R10 set beats clear on left flag");
        rp(0, 1, 0, 0, HI); lp(0, 1, 0, 0, LO); tick();
        chk(r_irq_n, 1'b1, "R3 final clear");
        chk(l_irq_n, 1'b1, "R5 final clear");
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_left_to_right();
        t_right_to_left();
        t_standby();
        t_other_addr();
        t_blocked();
        t_set_wins();
        done = 1;
        summary();
    end

endmodule